// File: doc/BRIEF.md
# HDLC Frame Receiver with Frame Checks

This block recovers HDLC frames from one serial channel. Each cycle in which `bit_en_i` is high carries one line bit. The block then finds the frame boundaries, drops the zeros the sender inserted, assembles octets with the first received bit in bit 0, and checks the trailing frame check sequence. The check sequence is a 16-bit or a 32-bit CRC, and the width is picked by an input. It delivers the payload octets one per strobe. The first octet of a frame is marked, and each frame ends with a separate end strobe that carries four status bits.

A transparent mode skips all framing and passes every eight received bits out as one octet. A rate-reduction option discards one bit out of every eight-bit slot. This serves links where only seven bits of each slot carry data. The configuration inputs are expected to stay unchanged between resets.

Top module: `hdlc_rx_frame`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `sof_o`, `eof_o` and `status_o` are all 0.
- R2: An octet is delivered on `data_o` with `valid_o` high one cycle after the enabled bit that completes it. `sof_o` is high only together with the first octet of a frame. `eof_o` pulses one cycle after the final bit of the closing flag (pattern 0111_1110). `status_o` is nonzero only while `eof_o` is high.
- R3: Inside a frame, a 0 received after exactly five consecutive 1s is discarded.
- R4: The check sequence is not delivered. With `crc32_i`=0 the last 2 octets before the closing flag are withheld. With `crc32_i`=1 the last 4 octets are withheld.
- R5: The CRC is processed least significant bit first in a shift-right register preset to all ones. The 16-bit form uses feedback 0x8408 and accepts residue 0xF0B8. The 32-bit form uses 0xEDB88320 and accepts 0xDEBB20E3. On a mismatch, status bit 0 is set.
- R6: Seven consecutive 1s inside a frame that holds at least one complete octet end the frame at once. `eof_o` pulses with `status_o`=4'b0010. The receiver then ignores input until the next flag.
- R7: A closing flag reached when the de-stuffed bit count is not a multiple of 8 gives `status_o`=4'b0100, with the CRC and length bits cleared.
- R8: Status bit 3 is set when the count of received octets, check sequence included, is below `min_len_i` or above `max_len_i`. Each bound is itself accepted.
- R9: With `transp_i`=1, every 8 kept bits form one output octet, counted from reset. `sof_o` and `eof_o` stay low.
- R10: A free-running slot counter counts enabled bits from reset. With `mode56_i`=1, the eighth bit of each slot of 8 is ignored in every mode.
- R11: A cycle with `bit_en_i` low changes nothing, and the next cycle shows no `valid_o` or `eof_o`.
- R12: Flags with no complete octet between them, and runs of 1s outside a frame, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial line bit |
| bit_en_i | input | 1 | Qualifies `bit_i` this cycle |
| crc32_i | input | 1 | 1 selects the 32-bit CRC, 0 the 16-bit CRC |
| transp_i | input | 1 | Transparent octet mode |
| mode56_i | input | 1 | Discard the eighth bit of every slot |
| min_len_i | input | LEN_W | Minimum frame length in octets |
| max_len_i | input | LEN_W | Maximum frame length in octets |
| data_o | output | 8 | Delivered octet |
| valid_o | output | 1 | `data_o` strobe |
| sof_o | output | 1 | First octet of a frame |
| eof_o | output | 1 | End-of-frame strobe |
| status_o | output | 4 | bit0 CRC error, bit1 abort, bit2 misaligned, bit3 length error |

## Verification
Every result is registered once behind the enabled bit that causes it. Octets, the closing end strobe and the abort end strobe are therefore all due in the cycle right after that bit's clock edge. The bench drives each bit at a falling edge and samples 1 time unit after the rising edge that accepts it. It also checks `eof_o` at exactly that point after the last flag bit and after the seventh abort one. A monitor at the falling edges collects octets and statuses, so strobes that arrive early, late or twice show up as queue mismatches.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_FRAME = 1'b1} rx_state_e;

  localparam int STAT_W     = 4;
  localparam int ST_CRC     = 0;
  localparam int ST_ABT     = 1;
  localparam int ST_ALN     = 2;
  localparam int ST_LEN     = 3;
  localparam int STUFF_ONES = 5;
  localparam int FLAG_ONES  = 6;
  localparam int FCS16_OCT  = 2;
  localparam int FCS32_OCT  = 4;

  localparam logic [31:0] POLY16 = 32'h0000_8408;
  localparam logic [31:0] POLY32 = 32'hEDB8_8320;
  localparam logic [15:0] GOOD16 = 16'hF0B8;
  localparam logic [31:0] GOOD32 = 32'hDEBB_20E3;

  function automatic logic [31:0] crc_octet(input logic [31:0] c, input logic [7:0] d,
                                            input logic wide);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (wide ? POLY32 : POLY16);
      if (!wide) r[31:16] = 16'h0;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_slot_mask.sv
module hdlc_rx_slot_mask #(
  parameter int SLOT_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode56_i,
  output logic keep_o
);
  localparam int CW = $clog2(SLOT_BITS);
  localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

  logic [CW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else if (en_i) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  assign keep_o = en_i & ~(mode56_i & (slot_q == LAST));
endmodule

// File: rtl/hdlc_rx_bitclass.sv
module hdlc_rx_bitclass
  import hdlc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bv_i,
  input  logic b_i,
  output logic flag_o,
  output logic abort_o,
  output logic data_v_o
);
  logic [3:0] ones_q;
  logic       stuff;

  assign flag_o   = bv_i & ~b_i & (ones_q == 4'(FLAG_ONES));
  assign stuff    = bv_i & ~b_i & (ones_q == 4'(STUFF_ONES));
  assign abort_o  = bv_i &  b_i & (ones_q == 4'(FLAG_ONES));
  assign data_v_o = bv_i & ~flag_o & ~stuff & ~abort_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (bv_i) begin
      if (!b_i) ones_q <= '0;
      else if (ones_q != 4'hF) ones_q <= ones_q + 4'd1;
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       wide_i,
  input  logic       byte_v_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);
  logic [31:0] crc_q;
  logic [31:0] preset;

  assign preset = wide_i ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= 32'hFFFF_FFFF;
    else if (init_i) crc_q <= preset;
    else if (byte_v_i) crc_q <= crc_octet(crc_q, byte_i, wide_i);
  end

  assign ok_o = wide_i ? (crc_q == GOOD32) : (crc_q[15:0] == GOOD16);
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int SLOT_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_en_i,
  input  logic              crc32_i,
  input  logic              transp_i,
  input  logic              mode56_i,
  input  logic [LEN_W-1:0]  min_len_i,
  input  logic [LEN_W-1:0]  max_len_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int FCS_MAX = FCS32_OCT;
  localparam int FILL_W  = $clog2(FCS_MAX + 1);

  logic              keep, flag, abort, data_v, crc_ok;
  rx_state_e         state_q;
  logic [7:0]        sh_q;
  logic [2:0]        bcnt_q;
  logic [LEN_W-1:0]  octs_q;
  logic [FILL_W-1:0] fill_q;
  logic              first_q;
  logic [7:0]        pipe_q [FCS_MAX];
  logic [7:0]        byte_new;
  logic              push, len_err;
  logic [FILL_W-1:0] fcs_n;
  logic [7:0]        pipe_out;
  logic [STAT_W-1:0] end_stat;

  hdlc_rx_slot_mask #(.SLOT_BITS(SLOT_BITS)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(bit_en_i), .mode56_i(mode56_i), .keep_o(keep)
  );

  hdlc_rx_bitclass u_cls (
    .clk_i(clk_i), .rst_ni(rst_ni), .bv_i(keep), .b_i(bit_i),
    .flag_o(flag), .abort_o(abort), .data_v_o(data_v)
  );

  assign byte_new = {bit_i, sh_q[7:1]};
  assign push     = ~transp_i & data_v & (state_q == ST_FRAME) & (bcnt_q == 3'd7);
  assign fcs_n    = crc32_i ? FILL_W'(FCS32_OCT) : FILL_W'(FCS16_OCT);
  assign pipe_out = crc32_i ? pipe_q[FCS32_OCT-1] : pipe_q[FCS16_OCT-1];
  assign len_err  = (octs_q < min_len_i) || (octs_q > max_len_i);

  hdlc_rx_crc u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(flag), .wide_i(crc32_i),
    .byte_v_i(push), .byte_i(byte_new), .ok_o(crc_ok)
  );

  always_comb begin
    end_stat = '0;
    if (bcnt_q != 3'd7) end_stat[ST_ALN] = 1'b1;
    else begin
      end_stat[ST_CRC] = ~crc_ok;
      end_stat[ST_LEN] = len_err;
    end
  end

  // withholding window: newest octet in stage 0
  for (genvar g = 0; g < FCS_MAX; g++) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else if (push) begin
        if (g == 0) pipe_q[g] <= byte_new;
        else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g - 1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      sh_q     <= '0;
      bcnt_q   <= '0;
      octs_q   <= '0;
      fill_q   <= '0;
      first_q  <= 1'b0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      sof_o    <= 1'b0;
      eof_o    <= 1'b0;
      status_o <= '0;
    end else begin
      valid_o  <= 1'b0;
      sof_o    <= 1'b0;
      eof_o    <= 1'b0;
      status_o <= '0;
      if (transp_i) begin
        if (keep) begin
          sh_q   <= byte_new;
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            valid_o <= 1'b1;
            data_o  <= byte_new;
          end
        end
      end else if (flag) begin
        if (state_q == ST_FRAME && octs_q != '0) begin
          eof_o    <= 1'b1;
          status_o <= end_stat;
        end
        state_q <= ST_FRAME;
        bcnt_q  <= '0;
        octs_q  <= '0;
        fill_q  <= '0;
        first_q <= 1'b1;
      end else if (abort) begin
        if (state_q == ST_FRAME && octs_q != '0) begin
          eof_o            <= 1'b1;
          status_o[ST_ABT] <= 1'b1;
        end
        state_q <= ST_HUNT;
      end else if (data_v && state_q == ST_FRAME) begin
        sh_q   <= byte_new;
        bcnt_q <= bcnt_q + 3'd1;
        if (push) begin
          if (octs_q != '1) octs_q <= octs_q + 1'b1;
          if (fill_q == fcs_n) begin
            valid_o <= 1'b1;
            data_o  <= pipe_out;
            sof_o   <= first_q;
            first_q <= 1'b0;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_frame_chk.sv
module hdlc_rx_frame_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       transp_i,
  input logic       valid_o,
  input logic       sof_o,
  input logic       eof_o,
  input logic [3:0] status_o
);
  p_sof_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o);
  p_status_eof_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eof_o |-> (status_o == 4'b0000));
  p_quiet_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> (!valid_o && !eof_o));
  p_abort_alone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && status_o[1]) |-> (status_o == 4'b0010));
  p_align_alone_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && status_o[2]) |-> (status_o == 4'b0100));
  p_transp_noframe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transp_i |-> (!eof_o && !sof_o));
endmodule

bind hdlc_rx_frame hdlc_rx_frame_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .transp_i(transp_i),
  .valid_o(valid_o), .sof_o(sof_o), .eof_o(eof_o), .status_o(status_o)
);

// File: tb/hdlc_rx_frame_tb_top.sv
module hdlc_rx_frame_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;

  logic clk = 0, rst_ni = 0, bit_i = 0, bit_en_i = 0, crc32_i = 0, transp_i = 0, mode56_i = 0;
  logic [LEN_W-1:0] min_len_i = 1, max_len_i = 100;
  logic [7:0] data_o;
  logic valid_o, sof_o, eof_o;
  logic [3:0] status_o;

  int checks = 0, errors = 0, slot = 0, gap = 0, ones_run = 0, stall_at = -1;
  bit done = 0, s_eof;
  logic [7:0] rx_q[$];
  bit sof_q[$];
  logic [3:0] eof_q[$];
  logic [7:0] pl[16];
  logic [7:0] fb[20];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_frame #(.LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_en_i(bit_en_i), .crc32_i(crc32_i),
    .transp_i(transp_i), .mode56_i(mode56_i), .min_len_i(min_len_i), .max_len_i(max_len_i),
    .data_o(data_o), .valid_o(valid_o), .sof_o(sof_o), .eof_o(eof_o), .status_o(status_o)
  );

  always @(negedge clk) if (rst_ni) begin
    if (valid_o) begin rx_q.push_back(data_o); sof_q.push_back(sof_o); end
    if (eof_o) eof_q.push_back(status_o);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [7:0] d, input bit w);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      bit x;
      x = r[0] ^ d[i];
      r = r >> 1;
      if (x) r = r ^ (w ? 32'hEDB88320 : 32'h8408);
    end
    return r;
  endfunction

  task automatic drive_en(input bit b);
    @(negedge clk);
    bit_i = b; bit_en_i = 1;
    @(posedge clk); #1;
    s_eof = eof_o;
    bit_en_i = 0;
    slot = (slot + 1) % 8;
    for (int k = 0; k < gap; k++) begin
      bit_i = ~bit_i;
      @(posedge clk); #1;
    end
  endtask

  task automatic put_data(input bit b);
    if (mode56_i && slot == 7) drive_en(1'b1);
    drive_en(b);
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) put_data(i != 0 && i != 7);
    ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      put_data(b[i]);
      ones_run = b[i] ? ones_run + 1 : 0;
      if (ones_run == 5) begin put_data(1'b0); ones_run = 0; end
    end
  endtask

  task automatic stall();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); bit_i = 1;
      @(posedge clk); #1;
      chk(!valid_o && !eof_o, "R11 stall", {valid_o, eof_o}, 0);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input bit t, input bit m, input int mn, input int mx);
    @(negedge clk);
    rst_ni = 0; bit_en_i = 0; transp_i = t; mode56_i = m;
    min_len_i = LEN_W'(mn); max_len_i = LEN_W'(mx);
    idle(2);
    chk(!valid_o && !sof_o && !eof_o && status_o == 0, "R1 reset", {valid_o, sof_o, eof_o, status_o}, 0);
    @(negedge clk); rst_ni = 1;
    slot = 0; ones_run = 0;
    rx_q.delete(); sof_q.delete(); eof_q.delete();
  endtask

  task automatic run_frame(input int n, input bit w, input bit bad, input int extra,
                           input logic [3:0] exp_st, input bit cmp, input string tag);
    logic [31:0] c;
    int tot;
    crc32_i = w;
    c = w ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i < n; i++) begin fb[i] = pl[i]; c = crc_ref(c, pl[i], w); end
    c = ~c;
    tot = n + (w ? 4 : 2);
    for (int i = n; i < tot; i++) fb[i] = c[8*(i-n) +: 8];
    if (bad) fb[0] = fb[0] ^ 8'h01;
    rx_q.delete(); sof_q.delete(); eof_q.delete();
    send_flag();
    for (int i = 0; i < tot; i++) begin
      if (i == stall_at) stall();
      send_byte(fb[i]);
    end
    for (int k = 0; k < extra; k++) begin put_data(1'b0); ones_run = 0; end
    send_flag();
    chk(s_eof == 1, {tag, " eof timing"}, s_eof, 1);
    idle(3);
    chk(eof_q.size() == 1 && eof_q[0] == exp_st, {tag, " status"},
        eof_q.size() == 1 ? eof_q[0] : 32'hEE, exp_st);
    if (cmp) begin
      chk(rx_q.size() == n, {tag, " count"}, rx_q.size(), n);
      if (rx_q.size() == n)
        for (int i = 0; i < n; i++) begin
          chk(rx_q[i] == fb[i], {tag, " data"}, rx_q[i], fb[i]);
          chk(sof_q[i] == (i == 0), "R2 sof", sof_q[i], i == 0);
        end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tb[5];
    do_reset(0, 0, 1, 100);
    // R2 R3 R4 R10 sweep: widths, lengths, rate mode, enable gaps
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 2; g++) begin
        do_reset(0, m[0], 1, 100);
        gap = g;
        for (int w = 0; w < 2; w++)
          for (int n = 1; n <= 6; n++) begin
            for (int i = 0; i < n; i++) pl[i] = 8'(i*53 + n*29 + 8'h7E);
            if (n % 2 == 1) pl[0] = 8'hFF;
            run_frame(n, w[0], 0, 0, 4'b0000, 1, m ? "R10 R3 R4" : "R2 R3 R4");
          end
      end
    gap = 0;
    do_reset(0, 0, 1, 100);
    for (int i = 0; i < 6; i++) pl[i] = 8'(8'h3C + i);
    run_frame(3, 0, 1, 0, 4'b0001, 1, "R5 crc16");
    run_frame(3, 1, 1, 0, 4'b0001, 1, "R5 crc32");
    run_frame(3, 0, 0, 3, 4'b0100, 0, "R7 extra3");
    run_frame(4, 1, 0, 5, 4'b0100, 0, "R7 extra5");
    stall_at = 2;
    run_frame(5, 0, 0, 0, 4'b0000, 1, "R11 gap");
    stall_at = -1;
    // R8 bounds 5..6 octets
    do_reset(0, 0, 5, 6);
    run_frame(2, 0, 0, 0, 4'b1000, 1, "R8 short");
    run_frame(3, 0, 0, 0, 4'b0000, 1, "R8 min");
    run_frame(4, 0, 0, 0, 4'b0000, 1, "R8 max");
    run_frame(5, 0, 0, 0, 4'b1000, 1, "R8 long");
    run_frame(2, 0, 1, 0, 4'b1001, 1, "R8 short+crc");
    // R6 abort
    do_reset(0, 0, 1, 100);
    crc32_i = 0;
    send_flag();
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    for (int k = 0; k < 7; k++) put_data(1'b1);
    chk(s_eof == 1, "R6 abort timing", s_eof, 1);
    idle(3);
    chk(eof_q.size() == 1 && eof_q[0] == 4'b0010, "R6 abort status", eof_q.size() ? eof_q[0] : 32'hEE, 2);
    chk(rx_q.size() == 1 && rx_q[0] == 8'h01 && sof_q[0], "R6 partial data", rx_q.size(), 1);
    for (int k = 0; k < 9; k++) put_data(k % 2);
    idle(2);
    chk(eof_q.size() == 1 && rx_q.size() == 1, "R6 hunting", rx_q.size() + eof_q.size(), 2);
    run_frame(2, 0, 0, 0, 4'b0000, 1, "R6 recover");
    // R12 idle ones and back-to-back flags
    do_reset(0, 0, 1, 100);
    for (int k = 0; k < 20; k++) put_data(1'b1);
    send_flag(); send_flag(); send_flag();
    for (int k = 0; k < 20; k++) put_data(1'b1);
    idle(3);
    chk(rx_q.size() == 0 && eof_q.size() == 0, "R12 silence", rx_q.size() + eof_q.size(), 0);
    // R9 transparent, with and without R10 rate mode
    tb[0] = 8'h7E; tb[1] = 8'hFF; tb[2] = 8'h00; tb[3] = 8'hA5; tb[4] = 8'h3C;
    for (int m = 0; m < 2; m++) begin
      do_reset(1, m[0], 1, 100);
      for (int j = 0; j < 5; j++)
        for (int i = 0; i < 8; i++) put_data(tb[j][i]);
      idle(3);
      chk(rx_q.size() == 5 && eof_q.size() == 0, m ? "R10 transp count" : "R9 transp count", rx_q.size(), 5);
      if (rx_q.size() == 5)
        for (int j = 0; j < 5; j++) begin
          chk(rx_q[j] == tb[j], m ? "R10 transp data" : "R9 transp data", rx_q[j], tb[j]);
          chk(sof_q[j] == 0, "R9 no sof", sof_q[j], 0);
        end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule